// File: doc/BRIEF.md
# Lookahead Way-Allocation Engine

This block decides how many ways of a shared set-associative cache each of several cores may occupy. A free-running epoch timer starts the engine at a fixed interval. When it starts, the engine reads every per-core recency-position hit counter through a simple counter-read port. It turns each core's counters into a cumulative hit curve and then allocates ways in repeated rounds. Each core begins with one way. In every round the engine looks at every core and every extra allocation size that still fits. It scores each candidate by the hits it gains per added way. The winning core receives the whole winning block of ways.

The engine weighs multi-way steps as well as single-way steps. Because of this, a core whose gains only appear after several extra ways still gets them. A one-way-at-a-time greedy scheme would miss that case. Ratios are compared by cross-multiplication, so no divider is needed. When no remaining candidate gains any hits, the leftover ways are dealt out one per core in turn. The run ends with a one-cycle done pulse. At that moment the packed quota vector updates, and it then holds until the next run completes. Enforcing the quotas in the replacement logic belongs to another block.

Top module: `wa_lookahead_alloc`

## Requirements
- R1: While reset is high and after its release, `quota` is all zeros, and `done`, `busy` and `mon_rd_en` are low until the first run starts.
- R2: `busy` rises after clock edge number k*EPOCH_CYCLES counted from reset release (k = 1, 2, ...). Each run reads every counter exactly once through `mon_rd_en`, core 0 first and positions in ascending order within a core. Read data is expected one cycle after the request.
- R3: `done` is high for exactly one cycle per run. `quota` changes only in that cycle and holds its value at all other times, including while a later run is in progress.
- R4: In every result, each core's quota is at least 1 and all quotas sum to NUM_WAYS. Core c's quota sits at bits [c*QW +: QW], with QW = clog2(NUM_WAYS+1).
- R5: Each round considers, for every core with current allocation a, every size k from 1 to the number of unassigned ways. The gain is the sum of that core's counters at positions a..a+k-1. The candidate with the largest gain/k wins and receives k ways. Rounds repeat until no way is left.
- R6: When two candidates have equal gain per way, the lower core index wins. For one core, the smaller k wins.
- R7: When the best remaining gain of every core is zero, the unassigned ways are handed out one at a time, starting at core 0 and going up in index with wrap-around.
- R8: Counter values up to the full 2^CNT_W-1 are handled without overflow in the cumulative sums or the ratio comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_rd_en | output | 1 | Counter read request |
| mon_rd_core | output | CORE_W | Core whose counter is requested |
| mon_rd_pos | output | POS_W | Recency position requested (0 = most recent) |
| mon_rd_data | input | CNT_W | Counter value, valid one cycle after the request |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a new quota vector is presented |
| quota | output | NUM_CORES*QW | Packed per-core way quotas |

## Verification
Embedded properties watch the invariants on every cycle: the single-cycle done pulse, the quota held between pulses, the sum of the quotas and the one-way minimum per core, counter reads made only while busy, and each candidate block size kept within the unassigned ways. Whether the chosen split is actually the lookahead optimum cannot be seen by such properties. That is shown only by the bench's scenarios: it compares each quota vector with an independent model of the allocation rule. The directed cases also hit the points where the rule bends: a curve whose gains come late, equal ratios, zero utility that triggers the round-robin fill, and counters at full scale. The bench also checks the epoch spacing and the read order.

// File: rtl/wa_pkg.sv
package wa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SCAN,
    ST_APPLY,
    ST_FILL,
    ST_FINISH
  } wa_state_e;

endpackage

// File: rtl/wa_epoch_timer.sv
module wa_epoch_timer #(
  parameter int EPOCH_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (EPOCH_CYCLES > 2) ? $clog2(EPOCH_CYCLES) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(EPOCH_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wa_mu_compare.sv
module wa_mu_compare #(
  parameter int UW = 21,
  parameter int KW = 5
) (
  input  logic [UW-1:0] u_cand,
  input  logic [KW-1:0] k_cand,
  input  logic [UW-1:0] u_best,
  input  logic [KW-1:0] k_best,
  output logic          better
);
  localparam int PW = UW + KW;

  logic [PW-1:0] lhs, rhs;

  // u_cand/k_cand > u_best/k_best  <=>  u_cand*k_best > u_best*k_cand
  assign lhs    = PW'(u_cand) * PW'(k_best);
  assign rhs    = PW'(u_best) * PW'(k_cand);
  assign better = (lhs > rhs);

endmodule

// File: rtl/wa_prefix_store.sv
module wa_prefix_store #(
  parameter int N      = 4,
  parameter int W      = 16,
  parameter int CNT_W  = 16,
  parameter int SUM_W  = 21,
  parameter int CORE_W = 2,
  parameter int POS_W  = 4,
  parameter int QW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  output logic              rd_en,
  output logic [CORE_W-1:0] rd_core,
  output logic [POS_W-1:0]  rd_pos,
  input  logic [CNT_W-1:0]  rd_data,
  output logic              load_done,
  input  logic [CORE_W-1:0] a_core,
  input  logic [QW-1:0]     a_k,
  output logic [SUM_W-1:0]  a_val,
  input  logic [CORE_W-1:0] b_core,
  input  logic [QW-1:0]     b_k,
  output logic [SUM_W-1:0]  b_val
);
  localparam int DEPTH = N * W;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // mem[core*W + k-1] holds the sum of counters 0..k-1 of that core
  logic [SUM_W-1:0] mem [DEPTH];

  logic              cap_valid;
  logic [CORE_W-1:0] cap_core;
  logic [POS_W-1:0]  cap_pos;
  logic [SUM_W-1:0]  run_sum;
  logic [SUM_W-1:0]  next_sum;
  logic              rd_last, cap_last;

  function automatic logic [AW-1:0] addr_of(input logic [CORE_W-1:0] c, input int p);
    return AW'(int'(c) * W + p);
  endfunction

  assign rd_last  = (rd_core == CORE_W'(N - 1)) && (rd_pos == POS_W'(W - 1));
  assign cap_last = (cap_core == CORE_W'(N - 1)) && (cap_pos == POS_W'(W - 1));
  assign next_sum = ((cap_pos == '0) ? '0 : run_sum) + SUM_W'(rd_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en     <= 1'b0;
      rd_core   <= '0;
      rd_pos    <= '0;
      cap_valid <= 1'b0;
      cap_core  <= '0;
      cap_pos   <= '0;
      run_sum   <= '0;
      load_done <= 1'b0;
    end else begin
      load_done <= 1'b0;
      if (load_start) begin
        rd_en   <= 1'b1;
        rd_core <= '0;
        rd_pos  <= '0;
      end else if (rd_en) begin
        if (rd_last) begin
          rd_en <= 1'b0;
        end else if (rd_pos == POS_W'(W - 1)) begin
          rd_pos  <= '0;
          rd_core <= rd_core + 1'b1;
        end else begin
          rd_pos <= rd_pos + 1'b1;
        end
      end
      cap_valid <= rd_en;
      cap_core  <= rd_core;
      cap_pos   <= rd_pos;
      if (cap_valid) begin
        run_sum <= next_sum;
        if (cap_last) load_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_valid) mem[addr_of(cap_core, int'(cap_pos))] <= next_sum;
  end

  assign a_val = (a_k == '0) ? '0 : mem[addr_of(a_core, int'(a_k) - 1)];
  assign b_val = (b_k == '0) ? '0 : mem[addr_of(b_core, int'(b_k) - 1)];

endmodule

// File: rtl/wa_lookahead_alloc.sv
module wa_lookahead_alloc
  import wa_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int NUM_WAYS     = 16,
  parameter int CNT_W        = 16,
  parameter int EPOCH_CYCLES = 5_000_000,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int POS_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int QW     = $clog2(NUM_WAYS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    mon_rd_en,
  output logic [CORE_W-1:0]       mon_rd_core,
  output logic [POS_W-1:0]        mon_rd_pos,
  input  logic [CNT_W-1:0]        mon_rd_data,
  output logic                    busy,
  output logic                    done,
  output logic [NUM_CORES*QW-1:0] quota
);
  localparam int SUM_W = CNT_W + QW;

  wa_state_e         state;
  logic              tick, load_start, load_done;
  logic [QW-1:0]     alloc [NUM_CORES];
  logic [QW-1:0]     rem;
  logic [CORE_W-1:0] cur_c, best_c, rr;
  logic [QW-1:0]     cur_k, best_k, top_k;
  logic [SUM_W-1:0]  best_u, base_val, top_val, cand_u;
  logic              cand_better, scan_last;
  logic [NUM_CORES*QW-1:0] quota_q;
  logic              done_q;

  wa_epoch_timer #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  assign load_start = (state == ST_IDLE) && tick;

  wa_prefix_store #(
    .N(NUM_CORES), .W(NUM_WAYS), .CNT_W(CNT_W), .SUM_W(SUM_W),
    .CORE_W(CORE_W), .POS_W(POS_W), .QW(QW)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .load_start(load_start),
    .rd_en     (mon_rd_en),
    .rd_core   (mon_rd_core),
    .rd_pos    (mon_rd_pos),
    .rd_data   (mon_rd_data),
    .load_done (load_done),
    .a_core    (cur_c),
    .a_k       (alloc[cur_c]),
    .a_val     (base_val),
    .b_core    (cur_c),
    .b_k       (top_k),
    .b_val     (top_val)
  );

  assign top_k  = alloc[cur_c] + cur_k;
  assign cand_u = top_val - base_val;

  wa_mu_compare #(.UW(SUM_W), .KW(QW)) u_cmp (
    .u_cand(cand_u),
    .k_cand(cur_k),
    .u_best(best_u),
    .k_best(best_k),
    .better(cand_better)
  );

  assign scan_last = (cur_c == CORE_W'(NUM_CORES - 1)) && (cur_k == rem);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rem     <= '0;
      cur_c   <= '0;
      cur_k   <= '0;
      best_c  <= '0;
      best_k  <= '0;
      best_u  <= '0;
      rr      <= '0;
      quota_q <= '0;
      done_q  <= 1'b0;
      for (int c = 0; c < NUM_CORES; c++) alloc[c] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (tick) state <= ST_LOAD;
        ST_LOAD: begin
          if (load_done) begin
            for (int c = 0; c < NUM_CORES; c++) alloc[c] <= QW'(1);
            rem    <= QW'(NUM_WAYS - NUM_CORES);
            cur_c  <= '0;
            cur_k  <= QW'(1);
            best_c <= '0;
            best_k <= QW'(1);
            best_u <= '0;
            rr     <= '0;
            state  <= (NUM_WAYS == NUM_CORES) ? ST_FINISH : ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (cand_better) begin
            best_u <= cand_u;
            best_k <= cur_k;
            best_c <= cur_c;
          end
          if (scan_last) begin
            state <= ST_APPLY;
          end else if (cur_k == rem) begin
            cur_c <= cur_c + 1'b1;
            cur_k <= QW'(1);
          end else begin
            cur_k <= cur_k + 1'b1;
          end
        end
        ST_APPLY: begin
          if (best_u == '0) begin
            state <= ST_FILL;
          end else begin
            alloc[best_c] <= alloc[best_c] + best_k;
            rem           <= rem - best_k;
            cur_c  <= '0;
            cur_k  <= QW'(1);
            best_c <= '0;
            best_k <= QW'(1);
            best_u <= '0;
            state  <= (rem == best_k) ? ST_FINISH : ST_SCAN;
          end
        end
        ST_FILL: begin
          alloc[rr] <= alloc[rr] + 1'b1;
          rem       <= rem - 1'b1;
          rr        <= (rr == CORE_W'(NUM_CORES - 1)) ? '0 : rr + 1'b1;
          if (rem == QW'(1)) state <= ST_FINISH;
        end
        ST_FINISH: begin
          for (int c = 0; c < NUM_CORES; c++) quota_q[c*QW +: QW] <= alloc[c];
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = done_q;
  assign quota = quota_q;

  // ---------------- assertions ----------------
  int quota_sum;
  always_comb begin
    quota_sum = 0;
    for (int c = 0; c < NUM_CORES; c++) quota_sum += int'(quota[c*QW +: QW]);
  end

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_quota_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(quota));

  a_r4_sum_ways: assert property (@(posedge clk) disable iff (rst)
    done |-> (quota_sum == NUM_WAYS));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_min_chk
    a_r4_min_one: assert property (@(posedge clk) disable iff (rst)
      done |-> (quota[g*QW +: QW] != '0));
  end

  a_r2_reads_busy: assert property (@(posedge clk) disable iff (rst)
    mon_rd_en |-> busy);

  a_r5_block_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN) |-> (cur_k != '0 && cur_k <= rem &&
                            int'(top_k) <= NUM_WAYS));

endmodule

// File: tb/wa_lookahead_alloc_tb.sv
module wa_lookahead_alloc_tb;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int CW = 16;
  localparam int EP = 1000;
  localparam int QW = $clog2(W + 1);

  // per-core pattern: [21:20] kind (0 zero,1 flat,2 single spike,3 halving), [19:16] pos, [15:0] value
  function automatic logic [21:0] pc(input int kind, input int p, input int v);
    return {2'(kind), 4'(p), 16'(v)};
  endfunction

  localparam logic [87:0] TABLE [6] = '{
    {pc(2, 8, 900),  pc(1, 0, 50),  pc(3, 0, 3000), pc(3, 0, 1000)},
    {pc(3, 0, 500),  pc(0, 0, 0),   pc(1, 0, 40),   pc(2, 5, 300)},
    {pc(2, 2, 30),   pc(1, 0, 8),   pc(1, 0, 9),    pc(1, 0, 7)},
    {pc(3, 0, 200),  pc(3, 0, 400), pc(3, 0, 1600), pc(3, 0, 800)},
    {pc(0, 0, 0),    pc(0, 0, 0),   pc(0, 0, 0),    pc(2, 15, 1000)},
    {pc(0, 0, 0),    pc(1, 0, 299), pc(1, 0, 300),  pc(2, 12, 5000)}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mon_rd_en;
  logic [1:0] mon_rd_core;
  logic [3:0] mon_rd_pos;
  logic [CW-1:0] mon_rd_data;
  logic busy, done;
  logic [N*QW-1:0] quota;

  logic [15:0] hits [N][W];
  int exp_q [N];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wa_lookahead_alloc #(
    .NUM_CORES(N), .NUM_WAYS(W), .CNT_W(CW), .EPOCH_CYCLES(EP)
  ) u_dut (
    .clk(clk), .rst(rst),
    .mon_rd_en(mon_rd_en), .mon_rd_core(mon_rd_core), .mon_rd_pos(mon_rd_pos),
    .mon_rd_data(mon_rd_data),
    .busy(busy), .done(done), .quota(quota)
  );

  // counter-port responder: one cycle latency
  always_ff @(posedge clk) if (mon_rd_en) mon_rd_data <= hits[mon_rd_core][mon_rd_pos];

  // monitors
  int edges = 0;
  int rd_total = 0, rd_bad = 0, rises = 0, rise_bad = 0;
  logic busy_q = 1'b0;
  always @(posedge clk) if (!rst) edges <= edges + 1;
  always @(negedge clk) begin
    if (!rst) begin
      if (mon_rd_en) begin
        if (int'(mon_rd_core) != (rd_total % (N*W)) / W ||
            int'(mon_rd_pos) != rd_total % W) rd_bad = rd_bad + 1;
        rd_total = rd_total + 1;
      end
      if (busy && !busy_q) begin
        rises = rises + 1;
        if (edges % EP != 0) rise_bad = rise_bad + 1;
      end
      busy_q = busy;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int qv(input int c);
    return int'(quota[c*QW +: QW]);
  endfunction

  task automatic apply_row(input logic [87:0] row);
    for (int c = 0; c < N; c++) begin
      int kind, p, v;
      kind = int'(row[c*22+20 +: 2]);
      p    = int'(row[c*22+16 +: 4]);
      v    = int'(row[c*22 +: 16]);
      for (int k = 0; k < W; k++) begin
        case (kind)
          1: hits[c][k] = 16'(v);
          2: hits[c][k] = (k == p) ? 16'(v) : 16'd0;
          3: hits[c][k] = 16'(v >> k);
          default: hits[c][k] = 16'd0;
        endcase
      end
    end
  endtask

  function automatic longint cum(input int c, input int k);
    longint s = 0;
    for (int i = 0; i < k; i++) s += longint'(hits[c][i]);
    return s;
  endfunction

  // independent model of the allocation rule (R5, R6, R7)
  task automatic model();
    int a [N];
    int rem, bc, bk, rc;
    longint bu, u;
    for (int c = 0; c < N; c++) a[c] = 1;
    rem = W - N;
    while (rem > 0) begin
      bu = 0; bk = 1; bc = 0;
      for (int c = 0; c < N; c++)
        for (int k = 1; k <= rem; k++) begin
          u = cum(c, a[c] + k) - cum(c, a[c]);
          if (u * bk > bu * k) begin bu = u; bk = k; bc = c; end
        end
      if (bu == 0) begin
        rc = 0;
        while (rem > 0) begin a[rc]++; rem--; rc = (rc + 1) % N; end
      end else begin
        a[bc] += bk; rem -= bk;
      end
    end
    for (int c = 0; c < N; c++) exp_q[c] = a[c];
  endtask

  task automatic run_epoch(input string tag);
    int rd0, t, s, mn;
    rd0 = rd_total;
    t = 0;
    while (!done && t < 4*EP) begin @(negedge clk); t++; end
    check(done == 1'b1, "R3 done seen", done, 1);
    for (int c = 0; c < N; c++)
      check(qv(c) == exp_q[c], $sformatf("%s quota core %0d", tag, c), qv(c), exp_q[c]);
    s = 0; mn = W;
    for (int c = 0; c < N; c++) begin s += qv(c); if (qv(c) < mn) mn = qv(c); end
    check(s == W, "R4 quota sum", s, W);
    check(mn >= 1, "R4 minimum quota", mn, 1);
    check(rd_total - rd0 == N*W, "R2 reads per run", rd_total - rd0, N*W);
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", done, 0);
  endtask

  task automatic set_exp(input int q0, input int q1, input int q2, input int q3);
    exp_q[0] = q0; exp_q[1] = q1; exp_q[2] = q2; exp_q[3] = q3;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [N*QW-1:0] last_q;
    apply_row('0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(quota == '0, "R1 quota reset", quota, 0);
    check(done == 1'b0, "R1 done reset", done, 0);
    check(busy == 1'b0, "R1 busy reset", busy, 0);
    check(mon_rd_en == 1'b0, "R1 no reads in reset", mon_rd_en, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && quota == '0, "R1 idle before first epoch", busy, 0);

    // table of scenarios checked against the model (R5)
    for (int i = 0; i < 6; i++) begin
      apply_row(TABLE[i]);
      model();
      run_epoch("R5 table");
    end

    // R5: late-gain curve, greedy would give core 0 everything
    apply_row({pc(0,0,0), pc(0,0,0), pc(2,3,90), pc(1,0,10)});
    set_exp(10, 4, 1, 1);
    run_epoch("R5 lookahead");

    // R6: equal ratios go to the lower core, one way at a time
    apply_row({pc(0,0,0), pc(0,0,0), pc(1,0,5), pc(1,0,5)});
    set_exp(13, 1, 1, 1);
    run_epoch("R6 tie");

    // R7: gains exhausted after two ways, then round robin from core 0
    apply_row('0);
    hits[0][1] = 16'd20;
    hits[0][2] = 16'd20;
    set_exp(6, 4, 3, 3);
    run_epoch("R7 fill after gains");

    // R8: full-scale counters
    apply_row({pc(1,0,65535), pc(1,0,65534), pc(1,0,65534), pc(1,0,65534)});
    set_exp(1, 1, 1, 13);
    run_epoch("R8 full scale");

    // R3: quota holds while the next run is in progress
    last_q = quota;
    apply_row('0);
    while (!busy) @(negedge clk);
    repeat (30) @(negedge clk);
    check(quota == last_q, "R3 quota hold during run", quota, last_q);
    check(done == 1'b0, "R3 no done mid run", done, 0);

    check(rd_bad == 0, "R2 read order", rd_bad, 0);
    check(rise_bad == 0, "R2 epoch spacing", rise_bad, 0);
    check(rises == 11, "R2 run count", rises, 11);
    finish_run();
  end

endmodule